// File: doc/BRIEF.md
# Privileged Protection-Table Base Register

This block holds the base address of the first-level protection table in one 64-bit configuration register. Software reaches it through a system-register access port. Each request carries the requester's privilege level, a read/write flag and write data. Exactly one cycle later the block answers with a response strobe, read data, and either an undefined-instruction flag or a write-trap flag with an exception class. Only the most privileged level (level 3) may touch the register. A level-3 write is trapped instead of performed when the fine-grained write-trap feature is present and its enable for this register is set.

The block also drives the effective table base address. It is 52 bits wide: the stored 40-bit base field, shifted up by 12, with a number of low bits forced to zero. That number depends on two configuration codes, the physical-address-size code and the level-0 region-size code. The alignment is the larger of a 4 KB granule and the table's own size, so the larger one wins.

Request handling is a small state machine with four states:
- ST_IDLE: no response.
- ST_DONE: the access was accepted.
- ST_UNDEF: the privilege level was too low.
- ST_TRAP: the write was trapped.

Every cycle the machine moves to the state chosen by the current request: a request with level 0, 1 or 2 goes to ST_UNDEF; a trapped level-3 write goes to ST_TRAP; any other level-3 request goes to ST_DONE; no request goes to ST_IDLE. Transitions are taken from every state, so back-to-back requests are served on consecutive cycles.

Top module: `tbase_reg_unit`

## Requirements
- R1: After reset the stored base is zero, the effective base is zero and no response is signalled.
- R2: An accepted level-3 write stores write-data bits 39:0. Bits 63:40 of the write data are ignored, and read data bits 63:40 are always zero.
- R3: Every request with req_valid high produces rsp_valid high for exactly the next cycle. A cycle without a request produces rsp_valid low in the following cycle.
- R4: A request at level 0, 1 or 2 (req_el = 0, 1, 2) answers with rsp_undef=1, rsp_trap=0 and rsp_rdata=0, and leaves the stored base unchanged.
- R5: A level-3 write while trap_feat_present=1 and trap_wr_enable=1 answers with rsp_trap=1, rsp_ec=0x18 and rsp_undef=0, and leaves the stored base unchanged.
- R6: A level-3 write is trapped only when both trap inputs are 1, and a level-3 read is never trapped. In every non-trap response rsp_ec is 0.
- R7: Address-size code to width: 000→32, 001→36, 010→40, 011→42, 100→44, 101→48, 110→52.
- R8: Level-0 size code to width: 0000→30, 0100→34, 0110→36, 1001→39.
- R9: The effective base is {base, 12'b0} with bits [a-1:0] forced to zero, where a = max(12, addr_width − l0_width + 3).
- R10: Address-size code 111 is treated as 52. Any level-0 size code not listed in R8 is treated as 39.
- R11: The effective base follows a change of either configuration code in the same cycle, with no clock edge needed.
- R12: An accepted level-3 read returns {24'b0, base} as stored at the request's clock edge. A read issued in the cycle right after a write returns the newly written value. A write response carries rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_el | input | 2 | Privilege level of the requester |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| trap_feat_present | input | 1 | Fine-grained write-trap feature is present |
| trap_wr_enable | input | 1 | Write-trap enable for this register |
| pas_code | input | 3 | Physical-address-size code |
| l0sz_code | input | 4 | Level-0 region-size code |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_trap | output | 1 | Write-trap indication |
| rsp_ec | output | 6 | Exception class of the trap |
| eff_base | output | 52 | Aligned effective table base address |

## Verification
Two things can land in the same cycle: a register write and a change to the alignment codes. The bench issues a level-3 write while it also moves both codes to new values. After the edge it compares eff_base with the new base masked by the new alignment, so a stale value or a stale mask is caught. It also issues a write followed at once by a read. The read response is judged against the freshly written value, which shows that storage and read capture agree on the same edge.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_UNDEF = 2'd2,
        ST_TRAP  = 2'd3
    } acc_state_e;

    localparam logic [1:0] EL_TOP = 2'd3;

    // Address-size code to width in bits; unlisted codes take the widest.
    function automatic logic [6:0] pa_width(input logic [2:0] code);
        logic [6:0] w;
        unique case (code)
            3'b000:  w = 7'd32;
            3'b001:  w = 7'd36;
            3'b010:  w = 7'd40;
            3'b011:  w = 7'd42;
            3'b100:  w = 7'd44;
            3'b101:  w = 7'd48;
            default: w = 7'd52;
        endcase
        return w;
    endfunction

    // Level-0 size code to width in bits; unlisted codes take the widest.
    function automatic logic [6:0] l0_width(input logic [3:0] code);
        logic [6:0] w;
        unique case (code)
            4'b0000: w = 7'd30;
            4'b0100: w = 7'd34;
            4'b0110: w = 7'd36;
            default: w = 7'd39;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tbr_access_fsm.sv
module tbr_access_fsm
    import tbr_pkg::*;
#(
    parameter int              EL_W    = 2,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] EC_TRAP = 6'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [EL_W-1:0] req_el,
    input  logic            req_write,
    input  logic            trap_feat_present,
    input  logic            trap_wr_enable,
    output logic            wr_en,
    output logic            rd_en,
    output logic            rsp_valid,
    output logic            rsp_undef,
    output logic            rsp_trap,
    output logic [EC_W-1:0] rsp_ec
);

    acc_state_e state_q;
    acc_state_e state_d;
    logic       top_level;
    logic       trap_hit;

    assign top_level = (req_el == EL_W'(EL_TOP));
    assign trap_hit  = req_write && trap_feat_present && trap_wr_enable;

    // Next-state selection from the current request.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!top_level) begin
                state_d = ST_UNDEF;
            end else if (trap_hit) begin
                state_d = ST_TRAP;
            end else begin
                state_d = ST_DONE;
            end
        end
    end

    // Commit strobes for the store, taken in the request cycle.
    assign wr_en = (state_d == ST_DONE) &&  req_write;
    assign rd_en = (state_d == ST_DONE) && !req_write;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response outputs decoded from the state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_undef = 1'b0;
        rsp_trap  = 1'b0;
        rsp_ec    = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
            end
            ST_UNDEF: begin
                rsp_valid = 1'b1;
                rsp_undef = 1'b1;
            end
            ST_TRAP: begin
                rsp_valid = 1'b1;
                rsp_trap  = 1'b1;
                rsp_ec    = EC_TRAP;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/tbr_store.sv
module tbr_store #(
    parameter int REG_W  = 64,
    parameter int BASE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [BASE_W-1:0] base_q,
    output logic [REG_W-1:0]  rdata_q
);

    localparam int PAD_W = REG_W - BASE_W;

    logic [REG_W-1:0] view;

    generate
        if (PAD_W > 0) begin : g_pad
            assign view = {{PAD_W{1'b0}}, base_q};
        end else begin : g_nopad
            assign view = base_q[REG_W-1:0];
        end
    endgenerate

    // Base field storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wdata[BASE_W-1:0];
        end
    end

    // Read data, captured from the value held at the request edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= view;
        end else begin
            rdata_q <= '0;
        end
    end

endmodule

// File: rtl/tbr_align.sv
module tbr_align
    import tbr_pkg::*;
#(
    parameter int BASE_W  = 40,
    parameter int GRAN_SH = 12
) (
    input  logic [2:0]              pas_code,
    input  logic [3:0]              l0sz_code,
    input  logic [BASE_W-1:0]       base_q,
    output logic [BASE_W+GRAN_SH-1:0] eff_base
);

    localparam int PA_W = BASE_W + GRAN_SH;

    logic [6:0]      pa_w;
    logic [6:0]      l0_w;
    logic [6:0]      span;
    logic [6:0]      zero_bits;
    logic [PA_W-1:0] keep;
    logic [PA_W-1:0] raw;

    // Number of low zero bits: the larger of granule and table size.
    always_comb begin
        pa_w = pa_width(pas_code);
        l0_w = l0_width(l0sz_code);
        span = 7'd0;
        if ((pa_w + 7'd3) > (l0_w + 7'(GRAN_SH))) begin
            span = pa_w + 7'd3 - l0_w;
        end
        zero_bits = (span > 7'(GRAN_SH)) ? span : 7'(GRAN_SH);
    end

    generate
        for (genvar i = 0; i < PA_W; i++) begin : g_keep
            assign keep[i] = (7'(i) >= zero_bits);
        end
    endgenerate

    assign raw      = {base_q, {GRAN_SH{1'b0}}};
    assign eff_base = raw & keep;

endmodule

// File: rtl/tbase_reg_unit.sv
module tbase_reg_unit #(
    parameter int              REG_W   = 64,
    parameter int              BASE_W  = 40,
    parameter int              GRAN_SH = 12,
    parameter int              EL_W    = 2,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] EC_TRAP = 6'h18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [EL_W-1:0]           req_el,
    input  logic                      req_write,
    input  logic [REG_W-1:0]          req_wdata,
    input  logic                      trap_feat_present,
    input  logic                      trap_wr_enable,
    input  logic [2:0]                pas_code,
    input  logic [3:0]                l0sz_code,
    output logic                      rsp_valid,
    output logic [REG_W-1:0]          rsp_rdata,
    output logic                      rsp_undef,
    output logic                      rsp_trap,
    output logic [EC_W-1:0]           rsp_ec,
    output logic [BASE_W+GRAN_SH-1:0] eff_base
);

    logic              wr_en;
    logic              rd_en;
    logic [BASE_W-1:0] base_q;

    tbr_access_fsm #(
        .EL_W    (EL_W),
        .EC_W    (EC_W),
        .EC_TRAP (EC_TRAP)
    ) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_el            (req_el),
        .req_write         (req_write),
        .trap_feat_present (trap_feat_present),
        .trap_wr_enable    (trap_wr_enable),
        .wr_en             (wr_en),
        .rd_en             (rd_en),
        .rsp_valid         (rsp_valid),
        .rsp_undef         (rsp_undef),
        .rsp_trap          (rsp_trap),
        .rsp_ec            (rsp_ec)
    );

    tbr_store #(
        .REG_W  (REG_W),
        .BASE_W (BASE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (req_wdata),
        .base_q  (base_q),
        .rdata_q (rsp_rdata)
    );

    tbr_align #(
        .BASE_W  (BASE_W),
        .GRAN_SH (GRAN_SH)
    ) u_align (
        .pas_code  (pas_code),
        .l0sz_code (l0sz_code),
        .base_q    (base_q),
        .eff_base  (eff_base)
    );

endmodule

// File: rtl/tbr_chk.sv
module tbr_chk #(
    parameter int              REG_W   = 64,
    parameter int              BASE_W  = 40,
    parameter int              GRAN_SH = 12,
    parameter int              EL_W    = 2,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] EC_TRAP = 6'h18
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [EL_W-1:0]           req_el,
    input logic                      req_write,
    input logic [REG_W-1:0]          req_wdata,
    input logic                      trap_feat_present,
    input logic                      trap_wr_enable,
    input logic                      rsp_valid,
    input logic [REG_W-1:0]          rsp_rdata,
    input logic                      rsp_undef,
    input logic                      rsp_trap,
    input logic [EC_W-1:0]           rsp_ec,
    input logic [BASE_W+GRAN_SH-1:0] eff_base,
    input logic [BASE_W-1:0]         base_q
);

    localparam logic [EL_W-1:0] TOP = EL_W'(3);

    // R3
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    low_level_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el != TOP) |=> (rsp_undef && !rsp_trap && rsp_rdata == '0 && $stable(base_q)));

    // R5
    trapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == TOP && req_write && trap_feat_present && trap_wr_enable)
        |=> (rsp_trap && !rsp_undef && rsp_ec == EC_TRAP && $stable(base_q)));

    // R2
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == TOP && req_write && !(trap_feat_present && trap_wr_enable))
        |=> (base_q == $past(req_wdata[BASE_W-1:0])));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[REG_W-1:BASE_W] == '0);

    // R6
    ec_only_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_trap |-> (rsp_ec == '0 && !(rsp_undef && rsp_trap)));

    // R9
    granule_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_base[GRAN_SH-1:0] == '0);

endmodule

bind tbase_reg_unit tbr_chk #(
    .REG_W   (REG_W),
    .BASE_W  (BASE_W),
    .GRAN_SH (GRAN_SH),
    .EL_W    (EL_W),
    .EC_W    (EC_W),
    .EC_TRAP (EC_TRAP)
) u_tbr_chk (.*);

// File: tb/test_tbase_reg_unit.sv
`timescale 1ns/1ps
module test_tbase_reg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_el = 2'd0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        trap_feat_present = 1'b0;
    logic        trap_wr_enable = 1'b0;
    logic [2:0]  pas_code = 3'b000;
    logic [3:0]  l0sz_code = 4'b0000;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_undef;
    logic        rsp_trap;
    logic [5:0]  rsp_ec;
    logic [51:0] eff_base;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tbase_reg_unit i_tbase_reg_unit (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_el            (req_el),
        .req_write         (req_write),
        .req_wdata         (req_wdata),
        .trap_feat_present (trap_feat_present),
        .trap_wr_enable    (trap_wr_enable),
        .pas_code          (pas_code),
        .l0sz_code         (l0sz_code),
        .rsp_valid         (rsp_valid),
        .rsp_rdata         (rsp_rdata),
        .rsp_undef         (rsp_undef),
        .rsp_trap          (rsp_trap),
        .rsp_ec            (rsp_ec),
        .eff_base          (eff_base)
    );

    // {addr-size code, level-0 code, expected zero-bit count}
    localparam logic [11:0] VEC [16] = '{
        {3'b000, 4'b0000, 5'd12},
        {3'b001, 4'b0000, 5'd12},
        {3'b010, 4'b0000, 5'd13},
        {3'b011, 4'b0000, 5'd15},
        {3'b100, 4'b0000, 5'd17},
        {3'b101, 4'b0000, 5'd21},
        {3'b110, 4'b0000, 5'd25},
        {3'b110, 4'b0100, 5'd21},
        {3'b110, 4'b0110, 5'd19},
        {3'b110, 4'b1001, 5'd16},
        {3'b111, 4'b0000, 5'd25},
        {3'b110, 4'b0001, 5'd16},
        {3'b101, 4'b1111, 5'd12},
        {3'b100, 4'b0100, 5'd13},
        {3'b011, 4'b1001, 5'd12},
        {3'b010, 4'b0110, 5'd12}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge; returns at the next negedge with the response visible.
    task automatic issue(input logic [1:0] el, input logic wr, input logic [63:0] d);
        req_valid = 1'b1;
        req_el    = el;
        req_write = wr;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    function automatic logic [51:0] aligned(input logic [39:0] b, input int zb);
        logic [51:0] m;
        m = ~52'h0 << zb;
        return {b, 12'h000} & m;
    endfunction

    task automatic read_back(input string tag, input logic [39:0] exp);
        issue(2'd3, 1'b0, 64'h0);
        check({tag, " read rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " read data"}, rsp_rdata, {24'h0, exp});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1 eff_base in reset", 64'(eff_base), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
        read_back("R1", 40'h0);

        // R2 write with junk in upper bits; R3 response shape
        issue(2'd3, 1'b1, 64'hDEAD_BEEF_0123_4567);
        check("R3 write rsp_valid", 64'(rsp_valid), 64'd1);
        check("R12 write rsp_rdata zero", rsp_rdata, 64'h0);
        check("R6 write ec zero", 64'(rsp_ec), 64'd0);
        check("R3 write flags", {62'h0, rsp_undef, rsp_trap}, 64'd0);
        read_back("R2", 40'hEF_0123_4567);

        // R3 no request -> no response
        @(negedge clk);
        check("R3 idle no rsp", 64'(rsp_valid), 64'd0);

        // R4 lower levels
        for (int el = 0; el < 3; el++) begin
            issue(2'(el), 1'b1, 64'h0000_0011_1111_1111);
            check("R4 undef on write", {61'h0, rsp_valid, rsp_undef, rsp_trap}, 64'b110);
            check("R4 rdata zero", rsp_rdata, 64'h0);
        end
        issue(2'd1, 1'b0, 64'h0);
        check("R4 undef on read", {61'h0, rsp_valid, rsp_undef, rsp_trap}, 64'b110);
        check("R4 read rdata zero", rsp_rdata, 64'h0);
        read_back("R4 unchanged", 40'hEF_0123_4567);

        // R5 trapped write
        trap_feat_present = 1'b1;
        trap_wr_enable    = 1'b1;
        issue(2'd3, 1'b1, 64'h0000_0055_5555_5555);
        check("R5 trap flags", {61'h0, rsp_valid, rsp_undef, rsp_trap}, 64'b101);
        check("R5 trap ec", 64'(rsp_ec), 64'h18);
        // R6 read at top level with trap set is not trapped
        issue(2'd3, 1'b0, 64'h0);
        check("R6 read not trapped", {61'h0, rsp_valid, rsp_undef, rsp_trap}, 64'b100);
        check("R5 unchanged after trap", rsp_rdata, 64'h0000_00EF_0123_4567);

        // R6 feature present only / enable only
        trap_wr_enable = 1'b0;
        issue(2'd3, 1'b1, 64'h22);
        check("R6 present-only not trapped", 64'(rsp_trap), 64'd0);
        read_back("R6 present-only", 40'h22);
        trap_feat_present = 1'b0;
        trap_wr_enable    = 1'b1;
        issue(2'd3, 1'b1, 64'h33);
        check("R6 enable-only not trapped", 64'(rsp_trap), 64'd0);
        read_back("R6 enable-only", 40'h33);
        trap_wr_enable = 1'b0;

        // R12 write then read back-to-back
        req_valid = 1'b1; req_el = 2'd3; req_write = 1'b1; req_wdata = 64'h0000_00FF_FFFF_FFFF;
        @(negedge clk);
        req_write = 1'b0;
        check("R12 b2b write rsp", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 b2b read data", rsp_rdata, 64'h0000_00FF_FFFF_FFFF);

        // R7 R8 R9 R10 R11 alignment table, codes change without a clock edge
        for (int k = 0; k < 16; k++) begin
            pas_code  = VEC[k][11:9];
            l0sz_code = VEC[k][8:5];
            #1;
            check($sformatf("R9 R7 R8 R10 R11 vec %0d", k), 64'(eff_base),
                  64'(aligned(40'hFF_FFFF_FFFF, int'(VEC[k][4:0]))));
            @(negedge clk);
        end

        // Write and code change in the same cycle (R9, R11)
        pas_code  = 3'b101;
        l0sz_code = 4'b0100;
        issue(2'd3, 1'b1, 64'h0000_0012_3456_789F);
        check("R9 concurrent write+codes", 64'(eff_base),
              64'(aligned(40'h12_3456_789F, 17)));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule